// File: doc/BRIEF.md
# Shift-Sequence Program Counter Sequencer

This block produces the instruction fetch address for a small 4-bit controller. The program counter is 6 bits wide. It does not count in binary. Each time the core retires an instruction, the counter moves to the next state of a feedback shift sequence. A 4-bit page address sits above the counter, and the two together form a 10-bit ROM address. The block watches the opcode being retired and the status flag from the datapath. From these it decides whether the next address is the next sequence state, a branch or call target, or a saved return point.

Far jumps take two steps. A load-page opcode first writes a page buffer. A taken branch or call then moves that buffer into the page address. A call made outside any subroutine saves the already-advanced counter and the current page, then sets an in-subroutine latch. While the latch is set, the saved context is frozen. A further call exchanges the page address with the page buffer rather than overwriting the saved values. A return restores the saved context and clears the latch.

Top module: `shpc_sequencer`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, `fetch_addr` is 0x3C0 (page 0xF, counter 0) and `in_subroutine` is 0. The page buffer also resets to 0xF.
- R2: On an advance step, the new counter is the old counter shifted left by one bit and truncated to 6 bits. The new bit 0 is the inverse of (old bit 5 XOR old bit 4). For example, 0x00 becomes 0x01, and 0x3E becomes 0x3D.
- R3: Two states are exceptions on an advance step. 0x1F goes to 0x3F, and 0x3F goes to 0x3E.
- R4: When `step_en` is 0, `fetch_addr` and `in_subroutine` keep their values, whatever the opcode and status.
- R5: Opcodes 0x10 to 0x1F write their low 4 bits into the page buffer. The page address is left unchanged and the counter advances.
- R6: Opcodes 0x80 to 0xBF with status 1 load the counter with opcode bits 5:0 and copy the page buffer into the page address.
- R7: A branch (0x80 to 0xBF) or call (0xC0 to 0xFF) with status 0 is not taken. The counter advances, and the page address and latch keep their values.
- R8: Opcodes 0xC0 to 0xFF with status 1 and the latch clear save the advanced counter and the current page. They then load the counter with opcode bits 5:0, copy the page buffer into the page address and set the latch.
- R9: Opcode 0x0F with the latch set loads the counter and page from the saved values and clears the latch.
- R10: A taken call while the latch is set loads the counter with the immediate and exchanges the page address with the page buffer. The saved return context is left unchanged.
- R11: Opcode 0x0F with the latch clear acts as a plain advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| step_en | input | 1 | Retire the current opcode and update the fetch state |
| opcode | input | 8 | Opcode of the instruction being retired |
| status | input | 1 | Condition flag from the datapath |
| fetch_addr | output | 10 | ROM fetch address, page in bits 9:6 and counter in bits 5:0 |
| in_subroutine | output | 1 | Call latch: 1 while inside a subroutine |

## Verification
The assertions take `opcode`, `status` and `step_en` to be stable and known around every rising clock edge. They judge a step only by the opcode class and status present at that edge. The bench drives every input on the falling edge and holds it for a full cycle. It releases reset and then waits past the internal synchronizer before the first step, so no step falls inside the reset window.

// File: rtl/shpc_pkg.sv
package shpc_pkg;

  // Opcode classes seen by the sequencer
  typedef enum logic [2:0] {
    OPK_ADVANCE = 3'd0,
    OPK_LDPAGE  = 3'd1,
    OPK_BRANCH  = 3'd2,
    OPK_CALL    = 3'd3,
    OPK_RETURN  = 3'd4
  } op_kind_e;

  localparam int unsigned OPCODE_W = 8;
  localparam logic [OPCODE_W-1:0] RETURN_CODE = 8'h0F;

endpackage

// File: rtl/shpc_step.sv
// Next state of the shift-sequence program counter.
module shpc_step #(
  parameter int unsigned PC_W = 6
) (
  input  logic [PC_W-1:0] pc_cur,
  output logic [PC_W-1:0] pc_next
);
  localparam logic [PC_W-1:0] ALL_ONES  = {PC_W{1'b1}};
  localparam logic [PC_W-1:0] LOW_ONES  = ALL_ONES >> 1;

  logic feed_bit;

  always_comb begin
    if (pc_cur == LOW_ONES) begin
      feed_bit = 1'b1;
    end else if (pc_cur == ALL_ONES) begin
      feed_bit = 1'b0;
    end else begin
      feed_bit = ~(pc_cur[PC_W-1] ^ pc_cur[PC_W-2]);
    end
    pc_next = {pc_cur[PC_W-2:0], feed_bit};
  end
endmodule

// File: rtl/shpc_decode.sv
// Sorts the retired opcode into a sequencer class and extracts immediates.
module shpc_decode
  import shpc_pkg::*;
#(
  parameter int unsigned PC_W = 6,
  parameter int unsigned PG_W = 4
) (
  input  logic [OPCODE_W-1:0] opcode,
  output op_kind_e            kind,
  output logic [PC_W-1:0]     target,
  output logic [PG_W-1:0]     page_imm
);
  localparam logic [3:0] LDPAGE_HI = 4'h1;

  always_comb begin
    target   = opcode[PC_W-1:0];
    page_imm = opcode[PG_W-1:0];
    if (opcode[7:6] == 2'b10) begin
      kind = OPK_BRANCH;
    end else if (opcode[7:6] == 2'b11) begin
      kind = OPK_CALL;
    end else if (opcode[7:4] == LDPAGE_HI) begin
      kind = OPK_LDPAGE;
    end else if (opcode == RETURN_CODE) begin
      kind = OPK_RETURN;
    end else begin
      kind = OPK_ADVANCE;
    end
  end
endmodule

// File: rtl/shpc_context.sv
// Saved return counter, saved page and call latch.
module shpc_context #(
  parameter int unsigned PC_W = 6,
  parameter int unsigned PG_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_en,
  input  logic            restore_en,
  input  logic [PC_W-1:0] save_pc,
  input  logic [PG_W-1:0] save_page,
  output logic [PC_W-1:0] ret_pc,
  output logic [PG_W-1:0] ret_page,
  output logic            latch_q
);
  logic [PC_W-1:0] ret_pc_d;
  logic [PG_W-1:0] ret_page_d;
  logic            latch_d;

  always_comb begin
    ret_pc_d   = ret_pc;
    ret_page_d = ret_page;
    latch_d    = latch_q;
    if (save_en) begin
      ret_pc_d   = save_pc;
      ret_page_d = save_page;
      latch_d    = 1'b1;
    end else if (restore_en) begin
      latch_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_pc   <= '0;
      ret_page <= '0;
      latch_q  <= 1'b0;
    end else begin
      ret_pc   <= ret_pc_d;
      ret_page <= ret_page_d;
      latch_q  <= latch_d;
    end
  end
endmodule

// File: rtl/shpc_sequencer.sv
// Fetch-address sequencer: shift-sequence counter, paging, call/return.
module shpc_sequencer
  import shpc_pkg::*;
#(
  parameter int unsigned PC_W = 6,
  parameter int unsigned PG_W = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic [OPCODE_W-1:0]     opcode,
  input  logic                    status,
  output logic [PG_W+PC_W-1:0]    fetch_addr,
  output logic                    in_subroutine
);
  localparam logic [PG_W-1:0] PAGE_RESET = {PG_W{1'b1}};

  // Reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  // State
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PG_W-1:0] page_q, page_d;
  logic [PG_W-1:0] pbuf_q, pbuf_d;

  logic [PC_W-1:0] pc_seq;
  op_kind_e        kind;
  logic [PC_W-1:0] target;
  logic [PG_W-1:0] page_imm;
  logic [PC_W-1:0] ret_pc;
  logic [PG_W-1:0] ret_page;
  logic            latch_q;
  logic            call_taken, save_en, restore_en;

  shpc_step #(.PC_W(PC_W)) u_step (
    .pc_cur  (pc_q),
    .pc_next (pc_seq)
  );

  shpc_decode #(.PC_W(PC_W), .PG_W(PG_W)) u_decode (
    .opcode   (opcode),
    .kind     (kind),
    .target   (target),
    .page_imm (page_imm)
  );

  assign call_taken = step_en && (kind == OPK_CALL) && status;
  assign save_en    = call_taken && !latch_q;
  assign restore_en = step_en && (kind == OPK_RETURN) && latch_q;

  shpc_context #(.PC_W(PC_W), .PG_W(PG_W)) u_context (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .save_en    (save_en),
    .restore_en (restore_en),
    .save_pc    (pc_seq),
    .save_page  (page_q),
    .ret_pc     (ret_pc),
    .ret_page   (ret_page),
    .latch_q    (latch_q)
  );

  // Next-state logic
  always_comb begin
    pc_d   = pc_q;
    page_d = page_q;
    pbuf_d = pbuf_q;
    if (step_en) begin
      pc_d = pc_seq;
      unique case (kind)
        OPK_LDPAGE: begin
          pbuf_d = page_imm;
        end
        OPK_BRANCH: begin
          if (status) begin
            pc_d   = target;
            page_d = pbuf_q;
          end
        end
        OPK_CALL: begin
          if (status) begin
            pc_d   = target;
            page_d = pbuf_q;
            if (latch_q) begin
              pbuf_d = page_q;
            end
          end
        end
        OPK_RETURN: begin
          if (latch_q) begin
            pc_d   = ret_pc;
            page_d = ret_page;
          end
        end
        default: begin
          pc_d = pc_seq;
        end
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= '0;
      page_q <= PAGE_RESET;
      pbuf_q <= PAGE_RESET;
    end else begin
      pc_q   <= pc_d;
      page_q <= page_d;
      pbuf_q <= pbuf_d;
    end
  end

  assign fetch_addr    = {page_q, pc_q};
  assign in_subroutine = latch_q;

endmodule

// File: rtl/shpc_sequencer_chk.sv
module shpc_sequencer_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       step_en,
  input logic [7:0] opcode,
  input logic       status,
  input logic [9:0] fetch_addr,
  input logic       in_subroutine
);
  logic plain;
  assign plain = !opcode[7] && (opcode != 8'h0F);

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (fetch_addr == 10'h3C0) && !in_subroutine);

  assert_wrap_low_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en && plain && fetch_addr[5:0] == 6'h1F |=> fetch_addr[5:0] == 6'h3F);

  assert_wrap_high_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en && plain && fetch_addr[5:0] == 6'h3F |=> fetch_addr[5:0] == 6'h3E);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !step_en |=> $stable(fetch_addr) && $stable(in_subroutine));

  assert_ldpage_keeps_page_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en && opcode[7:4] == 4'h1 |=> fetch_addr[9:6] == $past(fetch_addr[9:6]));

  assert_branch_target_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en && opcode[7:6] == 2'b10 && status |=> fetch_addr[5:0] == $past(opcode[5:0]));

  assert_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en && opcode[7] && !status |=> $stable(fetch_addr[9:6]) && $stable(in_subroutine));

  assert_call_enters_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en && opcode[7:6] == 2'b11 && status |=> in_subroutine && fetch_addr[5:0] == $past(opcode[5:0]));

  assert_return_leaves_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en && opcode == 8'h0F && in_subroutine |=> !in_subroutine);

  assert_return_idle_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en && opcode == 8'h0F && !in_subroutine |=> !in_subroutine && $stable(fetch_addr[9:6]));
endmodule

bind shpc_sequencer shpc_sequencer_chk u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .step_en       (step_en),
  .opcode        (opcode),
  .status        (status),
  .fetch_addr    (fetch_addr),
  .in_subroutine (in_subroutine)
);

// File: tb/shpc_sequencer_bench.sv
`timescale 1ns/1ps
module shpc_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic       status = 1'b0;
  logic [9:0] fetch_addr;
  logic       in_subroutine;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shpc_sequencer u_shpc_sequencer (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_en       (step_en),
    .opcode        (opcode),
    .status        (status),
    .fetch_addr    (fetch_addr),
    .in_subroutine (in_subroutine)
  );

  // {req[3:0], en, opcode[7:0], status, expected addr[9:0], expected latch}
  localparam int NV = 18;
  localparam logic [24:0] VEC [NV] = '{
    {4'd2,  1'b1, 8'h00, 1'b0, 10'h3C1, 1'b0}, // R2 0x00 -> 0x01
    {4'd2,  1'b1, 8'h00, 1'b0, 10'h3C3, 1'b0}, // R2
    {4'd4,  1'b0, 8'h80, 1'b1, 10'h3C3, 1'b0}, // R4 hold
    {4'd5,  1'b1, 8'h15, 1'b0, 10'h3C7, 1'b0}, // R5 buffer=5, page stays F
    {4'd7,  1'b1, 8'h9E, 1'b0, 10'h3CF, 1'b0}, // R7 branch not taken
    {4'd2,  1'b1, 8'h00, 1'b0, 10'h3DF, 1'b0}, // R2
    {4'd3,  1'b1, 8'h00, 1'b0, 10'h3FF, 1'b0}, // R3 0x1F -> 0x3F
    {4'd3,  1'b1, 8'h00, 1'b0, 10'h3FE, 1'b0}, // R3 0x3F -> 0x3E
    {4'd2,  1'b1, 8'h00, 1'b0, 10'h3FD, 1'b0}, // R2 0x3E -> 0x3D
    {4'd6,  1'b1, 8'h9E, 1'b1, 10'h15E, 1'b0}, // R6 page 5, pc 1E
    {4'd5,  1'b1, 8'h12, 1'b1, 10'h17C, 1'b0}, // R5 buffer=2
    {4'd8,  1'b1, 8'hC5, 1'b1, 10'h085, 1'b1}, // R8 save 39/5, page 2
    {4'd5,  1'b1, 8'h17, 1'b0, 10'h08B, 1'b1}, // R5 buffer=7
    {4'd10, 1'b1, 8'hCA, 1'b1, 10'h1CA, 1'b1}, // R10 page 7, buffer 2
    {4'd7,  1'b1, 8'hC3, 1'b0, 10'h1D5, 1'b1}, // R7 call not taken
    {4'd9,  1'b1, 8'h0F, 1'b0, 10'h179, 1'b0}, // R9 back to 39 on page 5
    {4'd11, 1'b1, 8'h0F, 1'b0, 10'h173, 1'b0}, // R11 plain advance
    {4'd10, 1'b1, 8'h80, 1'b1, 10'h080, 1'b0}  // R10 swapped buffer holds 2
  };

  task automatic check(input int req, input logic [9:0] exp_addr, input logic exp_lat);
    checks++;
    if (fetch_addr !== exp_addr || in_subroutine !== exp_lat) begin
      errors++;
      $display("FAIL R%0d: addr=%h latch=%b expected addr=%h latch=%b",
               req, fetch_addr, in_subroutine, exp_addr, exp_lat);
    end
  endtask

  task automatic step(input logic en, input logic [7:0] op, input logic st);
    @(negedge clk);
    step_en = en;
    opcode  = op;
    status  = st;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    step_en = 1'b0;
    #1;
    check(1, 10'h3C0, 1'b0); // R1 during reset
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, 10'h3C0, 1'b0); // R1 after release
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20], VEC[i][19:12], VEC[i][11]);
      check(int'(VEC[i][24:21]), VEC[i][10:1], VEC[i][0]);
    end
    // Mid-run reset while inside a subroutine: R1
    step(1'b1, 8'hC9, 1'b1);
    check(8, 10'h089, 1'b1); // R8 call to 09 on page 2
    do_reset();
    // R4: disabled step ignores a taken call
    step(1'b0, 8'hC7, 1'b1);
    check(4, 10'h3C0, 1'b0);
    // R11 with latch clear right after reset
    step(1'b1, 8'h0F, 1'b1);
    check(11, 10'h3C1, 1'b0);
    // R6: branch after reset takes the reset buffer page F
    step(1'b1, 8'hBF, 1'b1);
    check(6, 10'h3FF, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule